// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block sits inside a small CPU core. It runs from the moment the core accepts an interrupt until the first opcode fetch of the handler. The core raises a one-cycle accept pulse at an instruction boundary, or at a suspension point of a long string or multiply-accumulate instruction. With that pulse it supplies the live flag word, the 20-bit program counter and the 16-bit stack pointer. For a software interrupt it also supplies a flag and a 6-bit interrupt number.

The sequencer then owns a byte-wide memory bus and works through a fixed order of steps. For a hardware source it first reads the source number and the request level from the information locations and strobes a clear of that source's request bit. Next it saves a private copy of the entry flags, and clears the interrupt-enable, single-step and stack-select flags. It pushes four bytes holding the saved flags and the return address. It raises the priority level, fetches three vector bytes and loads the handler address. A one-cycle done pulse then tells the core to resume fetching at the new PC.

The updated flags, level, stack pointer and PC are held on the outputs until the next entry.

Top module: `irq_entry_seq`

## Requirements
- R1: While rst_ni is low and after its release, flg_o, ipl_o, sp_o and pc_o are 0, and done_o, ir_clr_o, mem_rd_o and mem_wr_o are low.
- R2: A hardware entry (sw_int_i low at accept) begins with a read at address 0, whose data bits 5:0 give the source number. It then reads address 1, whose data bits 2:0 give the request level. ir_clr_o is high for exactly one cycle, during the second read.
- R3: On entry the I flag (bit 6) and the D flag (bit 5) are cleared to 0. The U flag (bit 7) is cleared to 0 as well, except for a software entry whose number lies from 32 to 63 inclusive, where it keeps its entry value. All other flag bits keep their entry value, unless R6 changes them.
- R4: Four single-byte writes follow. Address SP-1 receives {F[15:12], PC[19:16]}, SP-2 receives F[7:0], SP-3 receives PC[15:8] and SP-4 receives PC[7:0]. F and PC are the entry values, and the addresses are 16-bit, wrap modulo 2^16 and are zero-extended. Flag bits 11:8 are not saved.
- R5: After the entry, sp_o equals the entry stack pointer minus 4, modulo 2^16.
- R6: The priority level is held in flag bits 14:12 and is also output on ipl_o. A hardware entry loads it with the level read in R2. A software entry leaves it at its entry value.
- R7: The vector address is VEC_BASE + 4 * number. The bytes at that address, +1 and +2 are read in that order and form pc_o = {byte2[3:0], byte1, byte0}.
- R8: done_o is high for one cycle, with pc_o already holding the handler address. It rises 10 clock edges after the accept edge for a hardware entry and 8 for a software entry. A read and a write never occur in the same cycle, and every access lasts one cycle.
- R9: An accept pulse that arrives while a sequence is running is ignored. The results and the bus traffic are those of the first entry alone, with a single done pulse.
- R10: A software entry takes its number from sw_num_i. It makes no information read and gives no ir_clr_o pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| accept_i | input | 1 | One-cycle interrupt accept pulse |
| sw_int_i | input | 1 | Accepted interrupt comes from a software INT |
| sw_num_i | input | 6 | Software interrupt number |
| flg_i | input | 16 | Flag word at entry |
| pc_i | input | 20 | Return address at entry |
| sp_i | input | 16 | Stack pointer at entry |
| mem_rdata_i | input | 8 | Read data, valid in the read cycle |
| mem_addr_o | output | 20 | Bus address |
| mem_rd_o | output | 1 | Read strobe |
| mem_wr_o | output | 1 | Write strobe |
| mem_wdata_o | output | 8 | Write data |
| ir_clr_o | output | 1 | Clear strobe for the accepted source's request bit |
| flg_o | output | 16 | Updated flag word |
| ipl_o | output | 3 | Current priority level |
| sp_o | output | 16 | Updated stack pointer |
| pc_o | output | 20 | Handler start address |
| done_o | output | 1 | Sequence complete |

## Verification
A wrong state register shows at the ports within one cycle. The bus strobe or its address departs from the fixed order, or done_o moves away from its edge 8 or 10. A mistake in the latched source number stays hidden until the vector reads, where it shows up as a wrong address and wrong handler PC. A mistake in the saved flag copy shows only in the stacked bytes. A mistake in the flag update or the level load shows on flg_o and ipl_o within one cycle of the accept edge or of the last push.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
  localparam int unsigned FLG_W   = 16;
  localparam int unsigned PC_W    = 20;
  localparam int unsigned FLG_I   = 6;
  localparam int unsigned FLG_D   = 5;
  localparam int unsigned FLG_U   = 7;
  localparam int unsigned IPL_LSB = 12;
  localparam int unsigned IPL_W   = 3;

  typedef enum logic [3:0] {
    ST_IDLE, ST_INFO0, ST_INFO1,
    ST_PUSH1, ST_PUSH2, ST_PUSH3, ST_PUSH4,
    ST_VEC0, ST_VEC1, ST_VEC2, ST_DONE
  } seq_st_e;
endpackage

// File: rtl/irq_flag_upd.sv
module irq_flag_upd
  import irq_entry_pkg::*;
#(
  parameter int unsigned NUM_W      = 6,
  parameter int unsigned KEEP_U_MIN = 32
) (
  input  logic [FLG_W-1:0] flg_i,
  input  logic             sw_i,
  input  logic [NUM_W-1:0] num_i,
  output logic [FLG_W-1:0] flg_o
);
  logic keep_u;
  assign keep_u = sw_i && (int'(num_i) >= KEEP_U_MIN);

  always_comb begin
    flg_o        = flg_i;
    flg_o[FLG_I] = 1'b0;
    flg_o[FLG_D] = 1'b0;
    if (!keep_u) flg_o[FLG_U] = 1'b0;
  end
endmodule

// File: rtl/irq_stack_pack.sv
module irq_stack_pack
  import irq_entry_pkg::*;
(
  input  logic [3:0]      flg_hi_i,
  input  logic [7:0]      flg_lo_i,
  input  logic [PC_W-1:0] pc_i,
  input  logic [1:0]      idx_i,
  output logic [7:0]      byte_o
);
  always_comb begin
    unique case (idx_i)
      2'd0:    byte_o = {flg_hi_i, pc_i[19:16]};
      2'd1:    byte_o = flg_lo_i;
      2'd2:    byte_o = pc_i[15:8];
      default: byte_o = pc_i[7:0];
    endcase
  end
endmodule

// File: rtl/irq_vec_asm.sv
module irq_vec_asm
  import irq_entry_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ld_i,
  input  logic [1:0]      idx_i,
  input  logic [7:0]      byte_i,
  output logic [PC_W-1:0] pc_o
);
  logic [7:0] lo_q, hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
      hi_q <= '0;
      pc_o <= '0;
    end else if (ld_i) begin
      unique case (idx_i)
        2'd0:    lo_q <= byte_i;
        2'd1:    hi_q <= byte_i;
        default: pc_o <= {byte_i[3:0], hi_q, lo_q};
      endcase
    end
  end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_entry_pkg::*;
#(
  parameter int unsigned AW         = 20,
  parameter int unsigned SP_W       = 16,
  parameter int unsigned NUM_W      = 6,
  parameter int unsigned LVL_W      = 3,
  parameter int unsigned KEEP_U_MIN = 32,
  parameter logic [19:0] VEC_BASE   = 20'hFFD00
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             accept_i,
  input  logic             sw_int_i,
  input  logic [NUM_W-1:0] sw_num_i,
  input  logic [FLG_W-1:0] flg_i,
  input  logic [PC_W-1:0]  pc_i,
  input  logic [SP_W-1:0]  sp_i,
  input  logic [7:0]       mem_rdata_i,
  output logic [AW-1:0]    mem_addr_o,
  output logic             mem_rd_o,
  output logic             mem_wr_o,
  output logic [7:0]       mem_wdata_o,
  output logic             ir_clr_o,
  output logic [FLG_W-1:0] flg_o,
  output logic [IPL_W-1:0] ipl_o,
  output logic [SP_W-1:0]  sp_o,
  output logic [PC_W-1:0]  pc_o,
  output logic             done_o
);
  localparam int unsigned PUSH_N = 4;

  seq_st_e          st_q;
  logic [FLG_W-1:0] flg_q, flg_ent;
  logic [3:0]       tmp_hi_q;
  logic [7:0]       tmp_lo_q;
  logic [PC_W-1:0]  pc_sv_q;
  logic [SP_W-1:0]  sp_q;
  logic [NUM_W-1:0] num_q;
  logic [LVL_W-1:0] lvl_q;
  logic             sw_q;

  logic [1:0]       push_idx, vec_idx;
  logic             is_push, is_vec;
  logic [7:0]       push_byte;
  logic [SP_W-1:0]  push_addr;
  logic [AW-1:0]    vec_addr;

  irq_flag_upd #(.NUM_W(NUM_W), .KEEP_U_MIN(KEEP_U_MIN)) u_flag_upd (
    .flg_i (flg_i),
    .sw_i  (sw_int_i),
    .num_i (sw_num_i),
    .flg_o (flg_ent)
  );

  irq_stack_pack u_stack_pack (
    .flg_hi_i (tmp_hi_q),
    .flg_lo_i (tmp_lo_q),
    .pc_i     (pc_sv_q),
    .idx_i    (push_idx),
    .byte_o   (push_byte)
  );

  irq_vec_asm u_vec_asm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ld_i   (is_vec),
    .idx_i  (vec_idx),
    .byte_i (mem_rdata_i),
    .pc_o   (pc_o)
  );

  always_comb begin
    is_push  = 1'b0;
    is_vec   = 1'b0;
    push_idx = 2'd0;
    vec_idx  = 2'd0;
    unique case (st_q)
      ST_PUSH1: begin is_push = 1'b1; push_idx = 2'd0; end
      ST_PUSH2: begin is_push = 1'b1; push_idx = 2'd1; end
      ST_PUSH3: begin is_push = 1'b1; push_idx = 2'd2; end
      ST_PUSH4: begin is_push = 1'b1; push_idx = 2'd3; end
      ST_VEC0:  begin is_vec  = 1'b1; vec_idx  = 2'd0; end
      ST_VEC1:  begin is_vec  = 1'b1; vec_idx  = 2'd1; end
      ST_VEC2:  begin is_vec  = 1'b1; vec_idx  = 2'd2; end
      default: ;
    endcase
  end

  // stack grows down one byte per push, wrapping within the 16-bit space
  assign push_addr = sp_q - SP_W'(push_idx) - SP_W'(1);
  assign vec_addr  = AW'(VEC_BASE) + (AW'(num_q) << 2) + AW'(vec_idx);

  always_comb begin
    mem_addr_o  = '0;
    mem_rd_o    = 1'b0;
    mem_wr_o    = 1'b0;
    mem_wdata_o = '0;
    ir_clr_o    = 1'b0;
    if (st_q == ST_INFO0) begin
      mem_rd_o = 1'b1;
    end else if (st_q == ST_INFO1) begin
      mem_rd_o   = 1'b1;
      mem_addr_o = AW'(1);
      ir_clr_o   = 1'b1;
    end else if (is_push) begin
      mem_wr_o    = 1'b1;
      mem_addr_o  = AW'(push_addr);
      mem_wdata_o = push_byte;
    end else if (is_vec) begin
      mem_rd_o   = 1'b1;
      mem_addr_o = vec_addr;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      flg_q    <= '0;
      tmp_hi_q <= '0;
      tmp_lo_q <= '0;
      pc_sv_q  <= '0;
      sp_q     <= '0;
      num_q    <= '0;
      lvl_q    <= '0;
      sw_q     <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (accept_i) begin
          tmp_hi_q <= flg_i[15:12];
          tmp_lo_q <= flg_i[7:0];
          flg_q    <= flg_ent;
          pc_sv_q  <= pc_i;
          sp_q     <= sp_i;
          sw_q     <= sw_int_i;
          num_q    <= sw_num_i;
          st_q     <= sw_int_i ? ST_PUSH1 : ST_INFO0;
        end
        ST_INFO0: begin
          num_q <= mem_rdata_i[NUM_W-1:0];
          st_q  <= ST_INFO1;
        end
        ST_INFO1: begin
          lvl_q <= mem_rdata_i[LVL_W-1:0];
          st_q  <= ST_PUSH1;
        end
        ST_PUSH1: st_q <= ST_PUSH2;
        ST_PUSH2: st_q <= ST_PUSH3;
        ST_PUSH3: st_q <= ST_PUSH4;
        ST_PUSH4: begin
          sp_q <= sp_q - SP_W'(PUSH_N);
          if (!sw_q) flg_q[IPL_LSB +: IPL_W] <= IPL_W'(lvl_q);
          st_q <= ST_VEC0;
        end
        ST_VEC0: st_q <= ST_VEC1;
        ST_VEC1: st_q <= ST_VEC2;
        ST_VEC2: st_q <= ST_DONE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign flg_o  = flg_q;
  assign ipl_o  = flg_q[IPL_LSB +: IPL_W];
  assign sp_o   = sp_q;
  assign done_o = (st_q == ST_DONE);
endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [19:0] mem_addr_o,
  input logic        mem_rd_o,
  input logic        mem_wr_o,
  input logic        ir_clr_o,
  input logic        done_o
);
  // R8
  rd_wr_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_wr_o));

  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R2
  ir_clr_after_info_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ir_clr_o |-> ($past(mem_rd_o) && ($past(mem_addr_o) == 20'd0)));

  // R4
  push_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_wr_o && $past(mem_wr_o)) |-> (mem_addr_o[15:0] == $past(mem_addr_o[15:0]) - 16'd1));

  // R7
  done_after_vec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(mem_rd_o) && !mem_rd_o && !mem_wr_o));
endmodule

bind irq_entry_seq irq_entry_seq_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mem_addr_o (mem_addr_o),
  .mem_rd_o   (mem_rd_o),
  .mem_wr_o   (mem_wr_o),
  .ir_clr_o   (ir_clr_o),
  .done_o     (done_o)
);

// File: tb/irq_entry_seq_bench.sv
`timescale 1ns/1ps
module irq_entry_seq_bench;
  localparam time         CLK_PERIOD = 10ns;
  localparam logic [19:0] VEC_BASE   = 20'hFFD00;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        accept = 1'b0, sw_int = 1'b0;
  logic [5:0]  sw_num = '0;
  logic [15:0] flg = '0;
  logic [19:0] pc = '0;
  logic [15:0] sp = '0;
  logic [7:0]  rdata;
  logic [19:0] addr;
  logic        rd, wr, ir_clr, done;
  logic [7:0]  wdata;
  logic [15:0] flg_out, sp_out;
  logic [2:0]  ipl_out;
  logic [19:0] pc_out;

  logic [5:0]  info_num = '0;
  logic [2:0]  info_lvl = '0;

  int n_chk = 0, n_fail = 0;
  int wr_n = 0, clr_n = 0, info_rd_n = 0, done_n = 0;
  logic [19:0] wr_addr [8];
  logic [7:0]  wr_data [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_entry_seq #(.VEC_BASE(VEC_BASE)) u_irq_entry_seq (
    .clk_i(clk), .rst_ni(rst_n), .accept_i(accept), .sw_int_i(sw_int),
    .sw_num_i(sw_num), .flg_i(flg), .pc_i(pc), .sp_i(sp),
    .mem_rdata_i(rdata), .mem_addr_o(addr), .mem_rd_o(rd), .mem_wr_o(wr),
    .mem_wdata_o(wdata), .ir_clr_o(ir_clr), .flg_o(flg_out), .ipl_o(ipl_out),
    .sp_o(sp_out), .pc_o(pc_out), .done_o(done)
  );

  function automatic logic [7:0] vec_byte(logic [19:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h96;
  endfunction

  function automatic logic [7:0] mem_byte(logic [19:0] a);
    if (a == 20'd0) return {2'b00, info_num};
    if (a == 20'd1) return {5'b0, info_lvl};
    return vec_byte(a);
  endfunction

  assign rdata = mem_byte(addr);

  always @(posedge clk) begin
    if (wr && wr_n < 8) begin
      wr_addr[wr_n] = addr;
      wr_data[wr_n] = wdata;
    end
    if (wr) wr_n++;
    if (ir_clr) clr_n++;
    if (rd && (addr == 20'd0 || addr == 20'd1)) info_rd_n++;
    if (done) done_n++;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic run_entry(input bit s, input logic [5:0] snum, input logic [5:0] inum,
                           input logic [2:0] ilvl, input logic [15:0] f, input logic [19:0] p,
                           input logic [15:0] stk, input bit poke);
    logic [5:0]  num;
    logic [15:0] ef;
    logic [19:0] va, epc;
    logic [7:0]  eb [4];
    int k;
    @(negedge clk);
    info_num = inum; info_lvl = ilvl;
    wr_n = 0; clr_n = 0; info_rd_n = 0; done_n = 0;
    sw_int = s; sw_num = snum; flg = f; pc = p; sp = stk;
    accept = 1'b1;
    k = 0;
    while (!done && k < 40) begin
      @(negedge clk);
      k++;
      if (k == 1) accept = 1'b0;
      if (poke && k == 3) begin accept = 1'b1; sw_int = 1'b1; sw_num = 6'd40; flg = 16'h0; sp = 16'h1234; end
      if (poke && k == 4) accept = 1'b0;
    end
    num = s ? snum : inum;
    ef = f; ef[6] = 1'b0; ef[5] = 1'b0;
    if (!(s && num >= 6'd32)) ef[7] = 1'b0;
    if (!s) ef[14:12] = ilvl;
    va  = VEC_BASE + {12'd0, num, 2'b00};
    epc = {vec_byte(va + 20'd2)[3:0], vec_byte(va + 20'd1), vec_byte(va)};
    eb[0] = {f[15:12], p[19:16]}; eb[1] = f[7:0]; eb[2] = p[15:8]; eb[3] = p[7:0];
    chk(k == (s ? 8 : 10), "R8 latency", k, s ? 8 : 10);
    chk(flg_out == ef, "R3 flags", flg_out, ef);
    chk(ipl_out == ef[14:12], "R6 ipl", ipl_out, ef[14:12]);
    chk(sp_out == stk - 16'd4, "R5 sp", sp_out, stk - 16'd4);
    chk(pc_out == epc, "R7 pc", pc_out, epc);
    for (int i = 0; i < 4; i++) begin
      chk(wr_addr[i] == {4'd0, stk - 16'(i + 1)}, "R4 push addr", wr_addr[i], {4'd0, stk - 16'(i + 1)});
      chk(wr_data[i] == eb[i], "R4 push data", wr_data[i], eb[i]);
    end
    repeat (4) @(negedge clk);
    chk(done_n == 1, "R8 single done", done_n, 1);
    chk(wr_n == 4, "R4 write count", wr_n, 4);
    chk(clr_n == (s ? 0 : 1), s ? "R10 no clear" : "R2 clear pulse", clr_n, s ? 0 : 1);
    chk(info_rd_n == (s ? 0 : 2), s ? "R10 no info read" : "R2 info reads", info_rd_n, s ? 0 : 2);
    if (poke) chk(flg_out == ef && sp_out == stk - 16'd4, "R9 busy accept ignored", sp_out, stk - 16'd4);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(flg_out == 0 && ipl_out == 0 && sp_out == 0 && pc_out == 0, "R1 reset regs", pc_out, 0);
    chk(!done && !ir_clr && !rd && !wr, "R1 reset strobes", {done, ir_clr, rd, wr}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(flg_out == 0 && !done && !rd && !wr, "R1 after release", flg_out, 0);
  endtask

  task automatic t_hw_basic;
    run_entry(1'b0, 6'd0, 6'd5, 3'd3, 16'hA0E5, 20'hABCDE, 16'h0800, 1'b0);
  endtask

  task automatic t_hw_top_num;
    run_entry(1'b0, 6'd0, 6'd63, 3'd7, 16'h70FF, 20'h01234, 16'h4000, 1'b0);
  endtask

  task automatic t_sw_low;
    run_entry(1'b1, 6'd10, 6'd3, 3'd5, 16'h30E0, 20'h54321, 16'h2000, 1'b0);
  endtask

  task automatic t_sw_edges;
    run_entry(1'b1, 6'd31, 6'd0, 3'd0, 16'h50C0, 20'h00FFF, 16'h1000, 1'b0);
    run_entry(1'b1, 6'd32, 6'd0, 3'd0, 16'h50C0, 20'h00FFF, 16'h1000, 1'b0);
    run_entry(1'b1, 6'd63, 6'd0, 3'd0, 16'h1080, 20'hFFFFF, 16'h0100, 1'b0);
  endtask

  task automatic t_busy_wrap;
    run_entry(1'b0, 6'd0, 6'd17, 3'd2, 16'h60E3, 20'h9A5A5, 16'h0002, 1'b1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog act=0 exp=1");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_hw_basic();
    t_hw_top_num();
    t_sw_low();
    t_sw_edges();
    t_busy_wrap();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule